// File: doc/BRIEF.md
# PCI Configuration Header with I/O Window Decode

This block holds the type-0 configuration header words that a single-function network adapter exposes to the host during enumeration, together with one I/O base address register (BAR) that places a 32-byte window anywhere in the 32-bit I/O space. The host reaches the header through a simple configuration port: a dword index, four byte enables, write data, and strobes for read and write. Read data is registered and appears on the cycle after the read strobe.

The class-code dword reports a network controller of the Ethernet sub-class. The dword that holds the header-type, latency-timer and cache-line bytes reads as zero. This marks a single-function device with the standard layout and a latency timer that forces release at the end of the current data phase when the device is preempted. The BAR keeps its 27 base bits through every reset, so a host that has already placed the device does not have to place it again after a soft or hard reset.

A bus target state machine supplies the address-phase address, the command nibble and the I/O-enable bit taken from its command register. The block answers with a combinational hit flag, which the target uses on the next cycle to claim the access.

Top module: `pci_cfg_hdr`

## Requirements
- R1: A read of dword index 2 returns 32'h0200_0000: base class 02h in bits 31:24, sub-class 00h in bits 23:16, programming interface 00h in bits 15:8 and revision 00h in bits 7:0. Writes to index 2 have no effect on what it returns.
- R2: A read of dword index 3 returns zero. This covers the header-type byte (bits 23:16), including its multi-function bit 23, and the latency-timer byte (bits 15:8). Writes to index 3 have no effect.
- R3: Bits 31:5 of the BAR (dword index 4) are written by a configuration write to index 4, one byte lane at a time: byte enable k controls bits 8k+7:8k. A lane whose enable is low keeps its old value.
- R4: BAR bits 4:0 always read 5'b00001: bit 0 is set to mark I/O space, and bits 4:1 are zero. Writes to these bits have no effect. After an all-ones write the BAR reads 32'hFFFF_FFE1, which signals a 32-byte window.
- R5: Reset does not change the BAR base bits. A value written before reset reads back unchanged after it.
- R6: `io_hit` is high in the same cycle whenever `io_en` is high, `bus_cmd` is an I/O read (4'b0010) or I/O write (4'b0011), and `bus_addr[31:5]` equals BAR bits 31:5. It is low when the address bits differ.
- R7: `io_hit` is low whenever `io_en` is low or `bus_cmd` is any value other than 4'b0010 or 4'b0011, whatever the address.
- R8: A read of any dword index other than 2, 3 or 4 returns zero. A write to such an index changes no readable state.
- R9: `cfg_rdata` is loaded on the clock edge where `cfg_rd` is high and is visible after that edge. It holds its value on every cycle without a read. Synchronous reset clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears read data only |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index |
| cfg_be | input | 4 | Byte enables for configuration writes |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Registered configuration read data |
| io_en | input | 1 | I/O-space enable from the command register |
| bus_cmd | input | 4 | Address-phase bus command |
| bus_addr | input | 32 | Address-phase bus address |
| io_hit | output | 1 | Combinational I/O window hit |

## Verification
The assertions assume that `cfg_rd` and `cfg_wr` are never high in the same cycle. They also assume that the bus address and command stay steady over the sampling edge, and that the BAR has been written before `io_en` is first raised, since the base bits power up undefined. The stimulus drives every input at the falling edge. It writes the BAR at the start of the vector table, before any access uses the window, and it pulses one configuration strobe at a time. It raises `io_en` only in the decode tests that follow the table.

// File: rtl/pci_cfg_hdr_pkg.sv
package pci_cfg_hdr_pkg;

    // Bus command nibbles used by the window decoder
    typedef enum logic [3:0] {
        CMD_IO_READ  = 4'b0010,
        CMD_IO_WRITE = 4'b0011
    } io_cmd_e;

    // Dword indices of the implemented header words
    localparam int unsigned DW_CLASS = 2;
    localparam int unsigned DW_MISC  = 3;
    localparam int unsigned DW_IOBAR = 4;

    typedef struct packed {
        logic [7:0] base_class;
        logic [7:0] sub_class;
        logic [7:0] prog_if;
        logic [7:0] revision;
    } class_word_t;

    typedef struct packed {
        logic [7:0] bist;
        logic       multi_func;
        logic [6:0] layout;
        logic [7:0] lat_timer;
        logic [7:0] line_size;
    } misc_word_t;

    localparam class_word_t CLASS_WORD = '{
        base_class: 8'h02,
        sub_class:  8'h00,
        prog_if:    8'h00,
        revision:   8'h00
    };

    localparam misc_word_t MISC_WORD = '{
        bist:       8'h00,
        multi_func: 1'b0,
        layout:     7'h00,
        lat_timer:  8'h00,
        line_size:  8'h00
    };

    function automatic logic is_io_cmd(input logic [3:0] cmd);
        return (cmd == CMD_IO_READ) || (cmd == CMD_IO_WRITE);
    endfunction

endpackage

// File: rtl/io_bar_reg.sv
module io_bar_reg #(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [ADDR_W/8-1:0]   be,
    input  logic [ADDR_W-1:0]     wdata,
    output logic [ADDR_W-1:0]     bar_word
);
    localparam int LANES = ADDR_W / 8;
    localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << WIN_LOG2;
    localparam logic [ADDR_W-1:0] LOW_WORD  = ADDR_W'(1);

    // No reset on purpose: the host-assigned base survives every reset.
    logic [ADDR_W-1:0] bar_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && be[g]) begin
                bar_q[8*g +: 8] <= wdata[8*g +: 8];
            end
        end
    end

    // Fixed low bits: I/O space indicator plus zeros for the window size.
    assign bar_word = (bar_q & BASE_MASK) | LOW_WORD;

endmodule

// File: rtl/io_hit_dec.sv
module io_hit_dec
    import pci_cfg_hdr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input  logic              io_en,
    input  logic [3:0]        bus_cmd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [ADDR_W-1:0] bar_word,
    output logic              io_hit
);
    localparam logic [ADDR_W-1:0] BASE_MASK = {ADDR_W{1'b1}} << WIN_LOG2;

    logic base_eq;

    always_comb begin
        base_eq = ((bus_addr ^ bar_word) & BASE_MASK) == '0;
        io_hit  = io_en && is_io_cmd(bus_cmd) && base_eq;
    end

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
    import pci_cfg_hdr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DW_AW  = 6
) (
    input  logic [DW_AW-1:0]  dw_addr,
    input  logic [ADDR_W-1:0] bar_word,
    output logic [ADDR_W-1:0] rd_word
);
    always_comb begin
        case (dw_addr)
            DW_AW'(DW_CLASS): rd_word = ADDR_W'(CLASS_WORD);
            DW_AW'(DW_MISC):  rd_word = ADDR_W'(MISC_WORD);
            DW_AW'(DW_IOBAR): rd_word = bar_word;
            default:          rd_word = '0;
        endcase
    end

endmodule

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr
    import pci_cfg_hdr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DW_AW    = 6,
    parameter int WIN_LOG2 = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_rd,
    input  logic                cfg_wr,
    input  logic [DW_AW-1:0]    cfg_dw_addr,
    input  logic [ADDR_W/8-1:0] cfg_be,
    input  logic [ADDR_W-1:0]   cfg_wdata,
    output logic [ADDR_W-1:0]   cfg_rdata,
    input  logic                io_en,
    input  logic [3:0]          bus_cmd,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic                io_hit
);
    logic [ADDR_W-1:0] bar_word;
    logic [ADDR_W-1:0] rd_word;
    logic              bar_wr;

    assign bar_wr = cfg_wr && (cfg_dw_addr == DW_AW'(DW_IOBAR));

    io_bar_reg #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_bar (
        .clk      (clk),
        .wr_en    (bar_wr),
        .be       (cfg_be),
        .wdata    (cfg_wdata),
        .bar_word (bar_word)
    );

    cfg_rd_mux #(.ADDR_W(ADDR_W), .DW_AW(DW_AW)) u_mux (
        .dw_addr  (cfg_dw_addr),
        .bar_word (bar_word),
        .rd_word  (rd_word)
    );

    io_hit_dec #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_dec (
        .io_en    (io_en),
        .bus_cmd  (bus_cmd),
        .bus_addr (bus_addr),
        .bar_word (bar_word),
        .io_hit   (io_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rdata <= '0;
        end else if (cfg_rd) begin
            cfg_rdata <= rd_word;
        end
    end

endmodule

// File: rtl/pci_cfg_hdr_chk.sv
module pci_cfg_hdr_chk
    import pci_cfg_hdr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DW_AW    = 6,
    parameter int WIN_LOG2 = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_rd,
    input logic [DW_AW-1:0]  cfg_dw_addr,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              io_en,
    input logic [3:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [ADDR_W-1:0] bar_word,
    input logic              io_hit
);
    localparam logic [WIN_LOG2-1:0] LOW_BITS = WIN_LOG2'(1);

    a_r1_class_word: assert property (@(posedge clk) disable iff (rst)
        cfg_rd && (cfg_dw_addr == DW_AW'(DW_CLASS)) |=> cfg_rdata == 32'h0200_0000);

    a_r4_bar_low_bits: assert property (@(posedge clk) disable iff (rst)
        cfg_rd && (cfg_dw_addr == DW_AW'(DW_IOBAR)) |=> cfg_rdata[WIN_LOG2-1:0] == LOW_BITS);

    // R2 and R8: every index other than the class word and the BAR reads zero
    a_r8_zero_words: assert property (@(posedge clk) disable iff (rst)
        cfg_rd && (cfg_dw_addr != DW_AW'(DW_CLASS)) && (cfg_dw_addr != DW_AW'(DW_IOBAR))
        |=> cfg_rdata == '0);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !cfg_rd |=> $stable(cfg_rdata));

    a_r7_hit_gated: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> io_en && is_io_cmd(bus_cmd));

    a_r6_hit_in_window: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> ((bus_addr ^ bar_word) >> WIN_LOG2) == '0);

endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(
    .ADDR_W(ADDR_W), .DW_AW(DW_AW), .WIN_LOG2(WIN_LOG2)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_rd      (cfg_rd),
    .cfg_dw_addr (cfg_dw_addr),
    .cfg_rdata   (cfg_rdata),
    .io_en       (io_en),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .bar_word    (bar_word),
    .io_hit      (io_hit)
);

// File: tb/sim_pci_cfg_hdr.sv
`timescale 1ns/1ps
module sim_pci_cfg_hdr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_rd = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_en = 1'b0;
    logic [3:0]  bus_cmd = '0;
    logic [31:0] bus_addr = '0;
    logic        io_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pci_cfg_hdr u0 (
        .clk(clk), .rst(rst), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_en(io_en), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .io_hit(io_hit)
    );

    // op 1 = read and compare, op 0 = write
    typedef struct packed {
        logic        op;
        logic [5:0]  dw;
        logic [3:0]  be;
        logic [31:0] data;
        logic [15:0] tag;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 6'd4, 4'hF, 32'h1234_5678, "R3"},
        '{1'b1, 6'd4, 4'h0, 32'h1234_5661, "R3"},
        '{1'b0, 6'd4, 4'h2, 32'hAAAA_BBCC, "R3"},
        '{1'b1, 6'd4, 4'h0, 32'h1234_BB61, "R3"},
        '{1'b0, 6'd4, 4'h8, 32'h9A00_0000, "R3"},
        '{1'b1, 6'd4, 4'h0, 32'h9A34_BB61, "R3"},
        '{1'b0, 6'd4, 4'h0, 32'hFFFF_FFFF, "R3"},
        '{1'b1, 6'd4, 4'h0, 32'h9A34_BB61, "R3"},
        '{1'b0, 6'd4, 4'hF, 32'hFFFF_FFFF, "R4"},
        '{1'b1, 6'd4, 4'h0, 32'hFFFF_FFE1, "R4"},
        '{1'b0, 6'd4, 4'h1, 32'h0000_001F, "R4"},
        '{1'b1, 6'd4, 4'h0, 32'hFFFF_FF01, "R4"},
        '{1'b1, 6'd2, 4'h0, 32'h0200_0000, "R1"},
        '{1'b0, 6'd2, 4'hF, 32'hFFFF_FFFF, "R1"},
        '{1'b1, 6'd2, 4'h0, 32'h0200_0000, "R1"},
        '{1'b0, 6'd3, 4'hF, 32'hFFFF_FFFF, "R2"},
        '{1'b1, 6'd3, 4'h0, 32'h0000_0000, "R2"},
        '{1'b0, 6'd7, 4'hF, 32'h0000_0000, "R8"},
        '{1'b1, 6'd4, 4'h0, 32'hFFFF_FF01, "R8"},
        '{1'b1, 6'd7, 4'h0, 32'h0000_0000, "R8"},
        '{1'b1, 6'd0, 4'h0, 32'h0000_0000, "R8"},
        '{1'b0, 6'd4, 4'hF, 32'hC000_0100, "R3"}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
        @(negedge clk);
        cfg_rd = 1'b1; cfg_dw_addr = dw;
        @(negedge clk);
        cfg_rd = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic hit_probe(input string req, input logic en, input logic [3:0] cmd,
                             input logic [31:0] a, input logic exp);
        @(negedge clk);
        io_en = en; bus_cmd = cmd; bus_addr = a;
        #1;
        check(req, {31'd0, io_hit}, {31'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9 reset value", cfg_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].op) begin
                cfg_read(VECS[i].dw, rd);
                check(string'(VECS[i].tag), rd, VECS[i].data);
            end else begin
                cfg_write(VECS[i].dw, VECS[i].be, VECS[i].data);
            end
        end

        // R3: final base value
        cfg_read(6'd4, rd);
        check("R3", rd, 32'hC000_0101);

        // R9: held while idle, and a write does not disturb it
        repeat (4) @(negedge clk);
        check("R9 hold", cfg_rdata, 32'hC000_0101);
        cfg_write(6'd7, 4'hF, 32'h5555_5555);
        check("R9 hold after write", cfg_rdata, 32'hC000_0101);

        // R5 and R9: reset clears read data but not the base
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R9 cleared by reset", cfg_rdata, 32'h0);
        cfg_read(6'd4, rd);
        check("R5", rd, 32'hC000_0101);

        // R6 and R7: window decode
        hit_probe("R6 low edge io read",   1'b1, 4'b0010, 32'hC000_0100, 1'b1);
        hit_probe("R6 high edge io write", 1'b1, 4'b0011, 32'hC000_011F, 1'b1);
        hit_probe("R6 just above",         1'b1, 4'b0010, 32'hC000_0120, 1'b0);
        hit_probe("R6 just below",         1'b1, 4'b0010, 32'hC000_00FF, 1'b0);
        hit_probe("R6 top bit differs",    1'b1, 4'b0011, 32'h4000_0100, 1'b0);
        hit_probe("R7 memory read cmd",    1'b1, 4'b0110, 32'hC000_0104, 1'b0);
        hit_probe("R7 config read cmd",    1'b1, 4'b1010, 32'hC000_0104, 1'b0);
        hit_probe("R7 io disabled",        1'b0, 4'b0010, 32'hC000_0104, 1'b0);

        @(negedge clk);
        io_en = 1'b0; bus_cmd = '0;
        finish_run();
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule